// File: doc/BRIEF.md
# CPU Clock Speed Switch Controller

This block holds the CPU speed mode and changes it only through a two-step sequence. Software first arms a change by writing the arm bit of a small control register. The next stop request from the CPU then commits the change: the speed toggles between normal and double, the arm bit clears, and a one-cycle pulse tells the clock divider to restart from zero. If the arm bit is clear, the same stop request puts the block into a low-power stopped state instead. The block leaves that state when any line of the active-low key input is pulled low.

A compatibility input selects the monochrome configuration, in which speed changes are not allowed. In that configuration an armed stop request raises a one-cycle error pulse. It does not change the speed, does not stop the block, and clears the arm bit.

The block also reports how many CPU clocks each machine cycle adds to the rest of the system. Clock generation and the divider itself sit outside the block.

Top module: `speed_switch`

## Requirements
- R1: After reset the speed is normal (`doubleSpeed`=0), the arm bit is clear, `stopped`=0, `divReset`=0 and `switchError`=0.
- R2: `regRdData` always reads `{doubleSpeed, 6'b111111, armBit}`, which is 0x7E with bit 7 holding the current speed (1 = double) and bit 0 holding the arm bit.
- R3: A write (`regWe`=1 with `stopReq`=0) loads the arm bit from `regWrData[0]` on the next clock edge. The other data bits are ignored and the speed cannot be written.
- R4: A stop request while armed, outside the monochrome configuration, toggles the speed and clears the arm bit on the next edge.
- R5: Each committed speed change produces `divReset` high for exactly one cycle, in the cycle after the commit edge.
- R6: A stop request while not armed sets `stopped` and leaves the speed unchanged.
- R7: While stopped, the block stays stopped while `keysN`=4'hF. It clears `stopped` on the edge after `keysN` differs from 4'hF.
- R8: With `monoMode`=1, an armed stop request pulses `switchError` for one cycle, keeps the speed, clears the arm bit and does not set `stopped`.
- R9: `cpuClocks` reads 2 in normal speed and 1 in double speed.
- R10: When a write and a stop request arrive in the same cycle, the stop request decides the outcome and the written arm bit is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| monoMode | input | 1 | Monochrome compatibility configuration; forbids speed changes |
| regWe | input | 1 | Control register write strobe |
| regWrData | input | 8 | Control register write data |
| regRdData | output | 8 | Control register read data |
| stopReq | input | 1 | One-cycle stop instruction strobe from the CPU |
| keysN | input | 4 | Active-low key lines |
| doubleSpeed | output | 1 | Current speed, 1 = double |
| stopped | output | 1 | Low-power stopped state |
| divReset | output | 1 | One-cycle divider restart pulse |
| switchError | output | 1 | One-cycle pulse on an illegal armed stop |
| cpuClocks | output | 2 | CPU clocks added per machine cycle |

## Verification
The assertions assume that `stopReq` is a single-cycle strobe from the CPU. They also assume that `monoMode` is a static configuration and does not change while a stop request is being taken. The stimulus drives every input only after the falling edge. It pulses `stopReq` for one cycle at a time and changes `monoMode` only with no stop request pending. The bench covers all 256 write values, every key pattern that leaves the stopped state, and repeated speed toggles in both directions.

// File: rtl/speed_switch_pkg.sv
package speed_switch_pkg;
  typedef struct packed {
    logic commit;
    logic halt;
    logic wake;
    logic fault;
    logic armLoad;
    logic armClear;
  } spdCtlT;
endpackage

// File: rtl/speed_switch_ctl.sv
module speed_switch_ctl
  import speed_switch_pkg::*;
#(
  parameter int KEY_W = 4
) (
  input  logic             stopReq,
  input  logic             regWe,
  input  logic             monoMode,
  input  logic [KEY_W-1:0] keysN,
  input  logic             armedQ,
  input  logic             stoppedQ,
  output spdCtlT           ctl
);
  localparam logic [KEY_W-1:0] KEYS_IDLE = '1;

  always_comb begin
    ctl.commit   = stopReq && armedQ && !monoMode;
    ctl.fault    = stopReq && armedQ && monoMode;
    ctl.halt     = stopReq && !armedQ;
    ctl.wake     = stoppedQ && (keysN != KEYS_IDLE);
    ctl.armClear = stopReq && armedQ;
    ctl.armLoad  = regWe && !stopReq;
  end
endmodule

// File: rtl/speed_switch_dp.sv
module speed_switch_dp
  import speed_switch_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  spdCtlT            ctl,
  input  logic              wrBit,
  output logic              armedQ,
  output logic              speedQ,
  output logic              stoppedQ,
  output logic              divRstQ,
  output logic              faultQ,
  output logic [DATA_W-1:0] rdData,
  output logic [1:0]        cpuClocks
);
  localparam int FILL_W = DATA_W - 2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armedQ   <= 1'b0;
      speedQ   <= 1'b0;
      stoppedQ <= 1'b0;
      divRstQ  <= 1'b0;
      faultQ   <= 1'b0;
    end else begin
      if (ctl.armClear)     armedQ <= 1'b0;
      else if (ctl.armLoad) armedQ <= wrBit;
      if (ctl.commit) speedQ <= ~speedQ;
      if (ctl.halt)      stoppedQ <= 1'b1;
      else if (ctl.wake) stoppedQ <= 1'b0;
      divRstQ <= ctl.commit;
      faultQ  <= ctl.fault;
    end
  end

  assign rdData    = {speedQ, {FILL_W{1'b1}}, armedQ};
  assign cpuClocks = speedQ ? 2'd1 : 2'd2;

  AST_DIV_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    divRstQ |=> !divRstQ) else $error("divReset wider than one cycle"); // R5
endmodule

// File: rtl/speed_switch.sv
module speed_switch
  import speed_switch_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int KEY_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              monoMode,
  input  logic              regWe,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              stopReq,
  input  logic [KEY_W-1:0]  keysN,
  output logic              doubleSpeed,
  output logic              stopped,
  output logic              divReset,
  output logic              switchError,
  output logic [1:0]        cpuClocks
);
  spdCtlT ctl;
  logic   armedQ;

  speed_switch_ctl #(.KEY_W(KEY_W)) u_ctl (
    .stopReq (stopReq),
    .regWe   (regWe),
    .monoMode(monoMode),
    .keysN   (keysN),
    .armedQ  (armedQ),
    .stoppedQ(stopped),
    .ctl     (ctl)
  );

  speed_switch_dp #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .wrBit    (regWrData[0]),
    .armedQ   (armedQ),
    .speedQ   (doubleSpeed),
    .stoppedQ (stopped),
    .divRstQ  (divReset),
    .faultQ   (switchError),
    .rdData   (regRdData),
    .cpuClocks(cpuClocks)
  );

  AST_ARM_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    regWe && !stopReq |=> regRdData[0] == $past(regWrData[0])) else $error("arm load"); // R3
  AST_SPEED_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    !stopReq |=> $stable(doubleSpeed)) else $error("speed moved"); // R6
  AST_SPEED_FLIP: assert property (@(posedge clk) disable iff (!rstN)
    stopReq && regRdData[0] && !monoMode |=> doubleSpeed != $past(doubleSpeed) && divReset)
    else $error("speed flip"); // R4
  AST_WAKE_ON_KEY: assert property (@(posedge clk) disable iff (!rstN)
    stopped && keysN != '1 && !stopReq |=> !stopped) else $error("no wake"); // R7
  AST_MONO_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    stopReq && regRdData[0] && monoMode |=> switchError && $stable(doubleSpeed) && !stopped)
    else $error("mono fault"); // R8
  AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rstN)
    stopReq && regRdData[0] |=> !regRdData[0]) else $error("arm not cleared"); // R10
endmodule

// File: tb/speed_switch_tb.sv
module speed_switch_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0, rstN = 1'b0, monoMode = 1'b0, regWe = 1'b0, stopReq = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [3:0] keysN = 4'hF;
  logic [7:0] regRdData;
  logic doubleSpeed, stopped, divReset, switchError;
  logic [1:0] cpuClocks;
  int total = 0, bad = 0, cycles = 0;
  logic expSpeed = 1'b0, expArm = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  speed_switch u_dut (
    .clk(clk), .rstN(rstN), .monoMode(monoMode), .regWe(regWe),
    .regWrData(regWrData), .regRdData(regRdData), .stopReq(stopReq),
    .keysN(keysN), .doubleSpeed(doubleSpeed), .stopped(stopped),
    .divReset(divReset), .switchError(switchError), .cpuClocks(cpuClocks)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: act=%0d exp<=%0d", cycles, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int expRead();
    return {24'd0, expSpeed, 6'b111111, expArm};
  endfunction

  task automatic wr(input logic [7:0] d);
    regWe = 1'b1; regWrData = d; step(); regWe = 1'b0;
    expArm = d[0];
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 read", regRdData, 8'h7E);
    chk("R1 stopped", stopped, 0);
    chk("R1 divReset", divReset, 0);
    chk("R1 error", switchError, 0);
    chk("R9 normal clocks", cpuClocks, 2);

    for (int v = 0; v < 256; v++) begin
      wr(v[7:0]);
      chk("R3 arm bit", regRdData[0], v[0]);
      chk("R2 read image", regRdData, expRead());
    end
    wr(8'h00);

    for (int n = 0; n < 4; n++) begin
      wr(8'hFE);
      chk("R3 bit0 only", regRdData, expRead());
      wr(8'h01);
      stopReq = 1'b1; step(); stopReq = 1'b0;
      expSpeed = ~expSpeed; expArm = 1'b0;
      chk("R4 speed toggled", doubleSpeed, expSpeed);
      chk("R4 arm cleared", regRdData, expRead());
      chk("R5 divReset pulse", divReset, 1);
      chk("R9 clocks", cpuClocks, expSpeed ? 1 : 2);
      chk("R6 not stopped", stopped, 0);
      step();
      chk("R5 divReset ends", divReset, 0);
    end

    wr(8'h01);
    stopReq = 1'b1; regWe = 1'b1; regWrData = 8'h01; step();
    stopReq = 1'b0; regWe = 1'b0;
    expSpeed = ~expSpeed; expArm = 1'b0;
    chk("R10 stop wins", regRdData, expRead());
    step();

    for (int k = 0; k < 16; k++) begin
      stopReq = 1'b1; step(); stopReq = 1'b0;
      chk("R6 stopped set", stopped, 1);
      chk("R6 speed kept", doubleSpeed, expSpeed);
      step();
      chk("R7 stays stopped", stopped, 1);
      keysN = k[3:0]; step();
      chk("R7 wake on key", stopped, (k == 15) ? 1 : 0);
      if (k == 15) begin
        keysN = 4'h7; step();
        chk("R7 late wake", stopped, 0);
      end
      keysN = 4'hF;
    end

    monoMode = 1'b1;
    for (int n = 0; n < 2; n++) begin
      wr(8'h01);
      stopReq = 1'b1; step(); stopReq = 1'b0;
      expArm = 1'b0;
      chk("R8 error pulse", switchError, 1);
      chk("R8 speed kept", regRdData, expRead());
      chk("R8 not stopped", stopped, 0);
      chk("R8 no divReset", divReset, 0);
      step();
      chk("R8 error ends", switchError, 0);
    end
    monoMode = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule